// File: doc/BRIEF.md
# Frame-Based Acquisition Controller

This block steers converter samples into a buffer RAM organised as frames of eight byte slots. The host loads a starting frame number and a count of frames to capture, then starts a run. Depending on a control bit, the run is started either by a host write strobe or by an external strobe pin. While the run is active, each incoming sample strobe writes its byte into the next slot of the current frame. When a frame fills, the frame address steps forward, wrapping after the last frame, and the frame counter steps down. When the counter reaches zero the run ends.

The status output `acquire` stays high for the whole run. Its inverse, `eventN`, is the completion signal a host process waits on. In six-stream mode only the first six slots of each frame are filled. The RAM address is the frame number times eight plus the slot index.

Top module: `acq_frame_ctrl`

## Requirements
- R1: The frame address register can be written by the host while `acquire` is low and is readable on `frameAddr`. It increases by one after every completed frame and wraps from 8191 to 0.
- R2: The 16-bit frame counter is loaded by the host while `acquire` is low. It decreases by one after every completed frame.
- R3: After the last slot of the frame that brings the counter to zero is written, `acquire` is low from the next cycle.
- R4: After an accepted start, `acquire` is high from the next cycle until the run ends.
- R5: When `extCtrlEn`=1 only `extStart` can start a run and `hostStartWe` is ignored. When `extCtrlEn`=0 only `hostStartWe` can start a run and `extStart` is ignored.
- R6: `eventN` is always the inverse of `acquire`.
- R7: While `acquire` is high, `sampleValid` writes a sample in the same cycle. On that write `ramWe`=1, `ramAddr` = frameAddr*8 + slot, and `ramData` = `sampleData`. Each run starts at slot 0.
- R8: With `sixStream`=0 a frame uses slots 0 to 7. With `sixStream`=1 a frame completes after slot 5, and slots 6 and 7 are never written.
- R9: A start request while `acquire` is high is ignored. This includes the cycle that writes the final sample.
- R10: A start request is ignored if the counter holds zero before that cycle. In that case `acquire` stays low and no write occurs.
- R11: While `acquire` is low, `sampleValid` causes no write. While `acquire` is high, host writes to the address register and the counter are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddrWe | input | 1 | Host write strobe for the frame address register |
| hostAddrData | input | 13 | Frame address write value |
| hostCountWe | input | 1 | Host write strobe for the frame counter |
| hostCountData | input | 16 | Frame count write value |
| hostStartWe | input | 1 | Host start strobe |
| extCtrlEn | input | 1 | 1 selects the external start pin |
| extStart | input | 1 | External start strobe |
| sixStream | input | 1 | 1 selects six slots per frame |
| sampleValid | input | 1 | Converter sample strobe |
| sampleData | input | 8 | Converter sample |
| ramWe | output | 1 | Buffer RAM write enable |
| ramAddr | output | 16 | Buffer RAM byte address |
| ramData | output | 8 | Buffer RAM write data |
| frameAddr | output | 13 | Current frame address (readback) |
| acquire | output | 1 | Run active |
| eventN | output | 1 | Active-low completion event |

## Verification
The stop of a run and a new start request can fall in the same cycle: the final sample strobe of the last frame coincides with a start pulse. The bench provokes this in both start modes and checks that `acquire` drops and stays low. A second coincidence, a host count write in the same cycle as a start while idle, shows that the start is judged on the old count. A behavioural reference model compares every output on every clock.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int SLOT_W = 3;
  localparam int FULL_LAST = 7;
  localparam int SIX_LAST = 5;

  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic clearSlot;
    logic advSlot;
    logic frameDone;
  } acqStrobe_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddrWe,
  input  logic              hostCountWe,
  input  logic              hostStartWe,
  input  logic              extCtrlEn,
  input  logic              extStart,
  input  logic              sampleValid,
  input  logic              sixStream,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              cntZero,
  input  logic              cntOne,
  output acqStrobe_t        strb,
  output logic              ramWe,
  output logic              busy
);
  logic busyQ;
  logic startReq;
  logic lastSlot;
  logic accept;

  assign startReq = extCtrlEn ? extStart : hostStartWe;
  assign lastSlot = sixStream ? (slotIdx == SLOT_W'(SIX_LAST)) : (slotIdx == SLOT_W'(FULL_LAST));
  assign accept   = busyQ && sampleValid;

  always_comb begin
    strb.loadAddr  = !busyQ && hostAddrWe;
    strb.loadCount = !busyQ && hostCountWe;
    strb.clearSlot = !busyQ && startReq && !cntZero;
    strb.advSlot   = accept && !lastSlot;
    strb.frameDone = accept && lastSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= 1'b0;
    else if (strb.clearSlot) busyQ <= 1'b1;
    else if (strb.frameDone && cntOne) busyQ <= 1'b0;
  end

  assign ramWe = accept;
  assign busy  = busyQ;

  a_r3_stop_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> cntZero);
  a_r10_zero_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && cntZero) |=> !busyQ);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !strb.frameDone) |=> busyQ);
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int FRAME_AW = 13,
  parameter int CNT_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  acqStrobe_t                 strb,
  input  logic [FRAME_AW-1:0]        addrIn,
  input  logic [CNT_W-1:0]           countIn,
  output logic [FRAME_AW-1:0]        frameAddr,
  output logic [SLOT_W-1:0]          slotIdx,
  output logic [FRAME_AW+SLOT_W-1:0] ramAddr,
  output logic                       cntZero,
  output logic                       cntOne
);
  logic [FRAME_AW-1:0] frameAddrQ;
  logic [CNT_W-1:0]    frameCntQ;
  logic [SLOT_W-1:0]   slotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameAddrQ <= '0;
      frameCntQ  <= '0;
      slotQ      <= '0;
    end else begin
      if (strb.loadAddr) frameAddrQ <= addrIn;
      else if (strb.frameDone) frameAddrQ <= frameAddrQ + 1'b1;

      if (strb.loadCount) frameCntQ <= countIn;
      else if (strb.frameDone) frameCntQ <= frameCntQ - 1'b1;

      if (strb.clearSlot || strb.frameDone) slotQ <= '0;
      else if (strb.advSlot) slotQ <= slotQ + 1'b1;
    end
  end

  assign frameAddr = frameAddrQ;
  assign slotIdx   = slotQ;
  assign ramAddr   = {frameAddrQ, slotQ};
  assign cntZero   = (frameCntQ == '0);
  assign cntOne    = (frameCntQ == CNT_W'(1));

  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> frameAddrQ == $past(frameAddrQ) + 1'b1);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> frameCntQ == $past(frameCntQ) - 1'b1);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAddr && !strb.frameDone) |=> $stable(frameAddrQ));
endmodule

// File: rtl/acq_frame_ctrl.sv
module acq_frame_ctrl
  import acq_pkg::*;
#(
  parameter int FRAME_AW = 13,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  localparam int RAM_AW  = FRAME_AW + SLOT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostAddrWe,
  input  logic [FRAME_AW-1:0] hostAddrData,
  input  logic                hostCountWe,
  input  logic [CNT_W-1:0]    hostCountData,
  input  logic                hostStartWe,
  input  logic                extCtrlEn,
  input  logic                extStart,
  input  logic                sixStream,
  input  logic                sampleValid,
  input  logic [DATA_W-1:0]   sampleData,
  output logic                ramWe,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [DATA_W-1:0]   ramData,
  output logic [FRAME_AW-1:0] frameAddr,
  output logic                acquire,
  output logic                eventN
);
  acqStrobe_t        strb;
  logic [SLOT_W-1:0] slotIdx;
  logic              cntZero;
  logic              cntOne;
  logic              busy;

  acq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddrWe(hostAddrWe), .hostCountWe(hostCountWe), .hostStartWe(hostStartWe),
    .extCtrlEn(extCtrlEn), .extStart(extStart), .sampleValid(sampleValid),
    .sixStream(sixStream), .slotIdx(slotIdx), .cntZero(cntZero), .cntOne(cntOne),
    .strb(strb), .ramWe(ramWe), .busy(busy)
  );

  acq_datapath #(.FRAME_AW(FRAME_AW), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addrIn(hostAddrData), .countIn(hostCountData),
    .frameAddr(frameAddr), .slotIdx(slotIdx), .ramAddr(ramAddr),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  assign ramData = sampleData;
  assign acquire = busy;
  assign eventN  = ~busy;
endmodule

// File: tb/acq_frame_ctrl_bench.sv
`timescale 1ns/1ps
module acq_frame_ctrl_bench;
  logic clk = 0, rstN = 0;
  logic hostAddrWe = 0, hostCountWe = 0, hostStartWe = 0;
  logic extCtrlEn = 0, extStart = 0, sixStream = 0, sampleValid = 0;
  logic [12:0] hostAddrData = 0;
  logic [15:0] hostCountData = 0;
  logic [7:0] sampleData = 0;
  logic ramWe, acquire, eventN;
  logic [15:0] ramAddr;
  logic [7:0] ramData;
  logic [12:0] frameAddr;

  int errors = 0, checks = 0;
  int mBusy = 0, mAddr = 0, mCnt = 0, mSlot = 0;
  int writesSeen = 0;

  always #5 clk = ~clk;

  acq_frame_ctrl u_acq_frame_ctrl (
    .clk(clk), .rstN(rstN), .hostAddrWe(hostAddrWe), .hostAddrData(hostAddrData),
    .hostCountWe(hostCountWe), .hostCountData(hostCountData), .hostStartWe(hostStartWe),
    .extCtrlEn(extCtrlEn), .extStart(extStart), .sixStream(sixStream),
    .sampleValid(sampleValid), .sampleData(sampleData), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .frameAddr(frameAddr),
    .acquire(acquire), .eventN(eventN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mAddr = 0; mCnt = 0; mSlot = 0;
    end else if (mBusy == 0) begin
      int oldCnt;
      bit st;
      oldCnt = mCnt;
      st = extCtrlEn ? extStart : hostStartWe;
      if (hostAddrWe) mAddr = hostAddrData;
      if (hostCountWe) mCnt = hostCountData;
      if (st && oldCnt != 0) begin mBusy = 1; mSlot = 0; end
    end else if (sampleValid) begin
      if (mSlot == (sixStream ? 5 : 7)) begin
        mSlot = 0; mAddr = (mAddr + 1) % 8192; mCnt = mCnt - 1;
        if (mCnt == 0) mBusy = 0;
      end else mSlot = mSlot + 1;
    end
  end

  // Compare every cycle, away from the edges
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      check("R4", acquire, mBusy);
      check("R6", eventN, !mBusy);
      check("R1", frameAddr, mAddr);
      check("R11", ramWe, mBusy && sampleValid);
      if (mBusy && sampleValid) begin
        check("R7", ramAddr, mAddr * 8 + mSlot);
        check("R7", ramData, sampleData);
        check("R8", (ramAddr % 8) <= (sixStream ? 5 : 7), 1);
      end
      if (ramWe) writesSeen++;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic clearIn();
    hostAddrWe = 0; hostCountWe = 0; hostStartWe = 0; extStart = 0; sampleValid = 0;
  endtask
  task automatic setup(input int a, input int c);
    tick(); clearIn(); hostAddrWe = 1; hostAddrData = 13'(a);
    hostCountWe = 1; hostCountData = 16'(c);
    tick(); clearIn();
  endtask
  task automatic pulseStart(input bit viaExt);
    tick(); clearIn(); if (viaExt) extStart = 1; else hostStartWe = 1;
    tick(); clearIn();
  endtask
  // feed n samples; optionally start on the final one; gap inserts idle cycles
  task automatic feed(input int n, input bit startOnLast, input bit gap);
    for (int i = 0; i < n; i++) begin
      tick(); clearIn(); sampleValid = 1; sampleData = 8'(i * 7 + 3);
      if (startOnLast && i == n - 1) begin extStart = 1; hostStartWe = 1; end
      if (gap && i % 3 == 1) begin tick(); clearIn(); end
    end
    tick(); clearIn();
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rstN = 1;
        #3;
        check("R4 reset", acquire, 0);
        check("R6 reset", eventN, 1);
        check("R1 reset", frameAddr, 0);
        check("R11 reset", ramWe, 0);

        // R8 full frames, R2 two frames, host start
        setup(10, 2);
        pulseStart(0);
        #3 check("R4 started", acquire, 1);
        feed(16, 0, 1);
        #3 check("R3 stopped", acquire, 0);
        check("R1 advanced", frameAddr, 12);

        // R10: counter now zero, start ignored, samples ignored
        writesSeen = 0;
        pulseStart(0);
        feed(4, 0, 0);
        #3 check("R10 no run", acquire, 0);
        check("R10 no writes", writesSeen, 0);

        // R10 coincident count write and start: judged on old (zero) count
        tick(); clearIn(); hostCountWe = 1; hostCountData = 1; hostStartWe = 1;
        tick(); clearIn();
        #3 check("R10 old count", acquire, 0);

        // R5 external mode: host start ignored, external start accepted
        setup(8191, 2);
        extCtrlEn = 1; sixStream = 1;
        pulseStart(0);
        #3 check("R5 host ignored", acquire, 0);
        pulseStart(1);
        #3 check("R5 ext start", acquire, 1);
        // R11 host writes while busy ignored
        tick(); clearIn(); hostAddrWe = 1; hostAddrData = 100; hostCountWe = 1; hostCountData = 50;
        tick(); clearIn();
        #3 check("R11 addr held", frameAddr, 8191);
        // R8 six slots, R1 wrap, R9 start on final sample
        feed(12, 1, 0);
        #3 check("R9 final start", acquire, 0);
        check("R1 wrap", frameAddr, 1);

        // R5 host mode: ext start ignored; R9 host start on final sample
        extCtrlEn = 0; sixStream = 0;
        setup(40, 1);
        pulseStart(1);
        #3 check("R5 ext ignored", acquire, 0);
        pulseStart(0);
        feed(8, 1, 0);
        #3 check("R9 host final", acquire, 0);
        check("R2 one frame", frameAddr, 41);
        repeat (3) tick();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule